// File: doc/BRIEF.md
# Radio core power sequencer

This controller brings an attached radio core's power domain up and down. It asks a power unit for domain power and waits for that unit's acknowledge before it tells the core its domain is live. It follows the core as the core goes to sleep or shuts down. Host-side controls wake the core, restart it after shutdown, or keep it asleep. Two debug controls bend the normal flow.

When automatic sequencing is off, the machine parks in its off state. Each of its four outputs can then be forced high, forced low, or left at the automatic value through a two-bit override field. An isolation output separates the domain whenever it is not fully active. The encoded state is visible on a port.

Top module: `rpwr_seq`

## Requirements
- R1: `state_o` uses OFF=0, INIT=1, PWRON=2, ACTIVE=3, SHUTDOWN=4, SLEEP=6. An active-low asynchronous reset puts the block in OFF with `pwr_req_o`=0, `dom_active_o`=0, `core_wakeup_o`=0 and `iso_o`=1.
- R2: While `seq_en_i`=0 the machine is in OFF from the next clock edge. With `seq_en_i`=1 it moves from OFF to INIT.
- R3: With `seq_en_i`=0, field `ovr_i[2k+1:2k]` controls output k (k=0 `pwr_req_o`, 1 `dom_active_o`, 2 `core_wakeup_o`, 3 `iso_o`). Code 3 drives the output to 1, code 2 drives it to 0, and codes 0 and 1 leave the automatic value.
- R4: With `seq_en_i`=1 the override fields have no effect on any output.
- R5: From INIT a core domain request moves the machine to PWRON. `pwr_req_o` is the registered value of "state is PWRON or ACTIVE". PWRON moves to ACTIVE only on a cycle where `pwr_ack_i` and `pwr_req_o` are both 1.
- R6: `dom_active_o` is 1 exactly while the state is ACTIVE, so it rises one cycle after the acknowledge is seen.
- R7: `iso_o` is 0 only in ACTIVE. When the machine leaves ACTIVE, `iso_o` rises in the same cycle and `pwr_req_o` falls one cycle later.
- R8: In ACTIVE, if the core drops its request (and the skip bit is 0), the machine goes to SLEEP. SLEEP returns to PWRON on a host wake or a new core request.
- R9: A host wake is acted on only in SLEEP. `core_wakeup_o` is then 1 for as long as that PWRON visit lasts.
- R10: A core shutdown indication moves ACTIVE or SLEEP to SHUTDOWN. SHUTDOWN ignores wake and core requests, and a host restart, acted on only there, moves it to INIT.
- R11: While stay-asleep is 1, SLEEP is not left for PWRON.
- R12: Debug force-sleep moves INIT, PWRON or ACTIVE to SLEEP and blocks any exit from SLEEP to PWRON.
- R13: The debug skip bit moves INIT to PWRON without a core request and keeps ACTIVE without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seq_en_i | input | 1 | Automatic sequencing enable |
| core_dom_req_i | input | 1 | Core asks for its power domain |
| core_shutdn_i | input | 1 | Core signals shutdown |
| host_wake_i | input | 1 | Host wake request |
| host_restart_i | input | 1 | Host restart request |
| stay_asleep_i | input | 1 | Keep the core asleep |
| dbg_force_sleep_i | input | 1 | Debug: force this machine to SLEEP |
| dbg_skip_req_i | input | 1 | Debug: act as if the core requested power |
| pwr_ack_i | input | 1 | Power unit acknowledge |
| ovr_i | input | 8 | Four two-bit override fields |
| pwr_req_o | output | 1 | Power request to the power unit |
| dom_active_o | output | 1 | Domain-active flag to the core |
| core_wakeup_o | output | 1 | Wakeup line to the core |
| iso_o | output | 1 | Isolation control |
| state_o | output | 3 | Encoded machine state |

## Verification
The bench uses the package defaults: four controlled outputs, each with a two-bit override field. This lets one vector walk visit every state and every exit, including the guarded ones: a wake in INIT or SHUTDOWN, an acknowledge that arrives before the request is out, and stay-asleep and force-sleep holding SLEEP. Directed tests then use every override code on the output whose automatic value differs from the forced one. They also repeat the override setting with sequencing enabled, to show it has no effect there.

// File: rtl/rpwr_pkg.sv
package rpwr_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_INIT   = 3'd1,
    ST_PWRON  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_SHUTDN = 3'd4,
    ST_SLEEP  = 3'd6
  } rpwr_state_e;

  localparam int unsigned NUM_OUT = 4;
  localparam int unsigned OVR_W   = 2;
  localparam int unsigned OVR_TOT = NUM_OUT * OVR_W;

  localparam int unsigned OUT_PWR  = 0;
  localparam int unsigned OUT_DOM  = 1;
  localparam int unsigned OUT_WAKE = 2;
  localparam int unsigned OUT_ISO  = 3;

  localparam logic [OVR_W-1:0] OVR_HI = 2'b11;
  localparam logic [OVR_W-1:0] OVR_LO = 2'b10;

  typedef struct packed {
    logic dom_req;
    logic shutdn;
    logic wake;
    logic restart;
    logic stay;
    logic fsleep;
    logic skip;
  } rpwr_ctl_t;
endpackage

// File: rtl/rpwr_fsm.sv
module rpwr_fsm
  import rpwr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seq_en_i,
  input  rpwr_ctl_t   ctl_i,
  input  logic        pwr_ack_i,
  input  logic        pwr_req_i,
  output rpwr_state_e state_o,
  output rpwr_state_e state_d_o,
  output logic        wake_go_o
);
  rpwr_state_e state_q, state_d;
  logic        wake_go;

  always_comb begin
    state_d = state_q;
    wake_go = 1'b0;
    if (!seq_en_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_INIT;
        ST_INIT: begin
          if (ctl_i.fsleep)                    state_d = ST_SLEEP;
          else if (ctl_i.dom_req || ctl_i.skip) state_d = ST_PWRON;
        end
        ST_PWRON: begin
          if (ctl_i.fsleep)                  state_d = ST_SLEEP;
          else if (pwr_ack_i && pwr_req_i)   state_d = ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (ctl_i.shutdn)                          state_d = ST_SHUTDN;
          else if (ctl_i.fsleep)                     state_d = ST_SLEEP;
          else if (!ctl_i.dom_req && !ctl_i.skip)    state_d = ST_SLEEP;
        end
        ST_SLEEP: begin
          if (ctl_i.shutdn) begin
            state_d = ST_SHUTDN;
          end else if (!ctl_i.fsleep && !ctl_i.stay &&
                       (ctl_i.wake || ctl_i.dom_req)) begin
            state_d = ST_PWRON;
            wake_go = ctl_i.wake;
          end
        end
        ST_SHUTDN: begin
          if (ctl_i.restart) state_d = ST_INIT;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign state_d_o = state_d;
  assign wake_go_o = wake_go;

  // R2
  seq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_en_i |=> state_q == ST_OFF);

  // R5
  ack_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWRON && !(pwr_ack_i && pwr_req_i)) |=> state_q != ST_ACTIVE);

  // R10
  shutdn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_en_i && state_q == ST_SHUTDN && !ctl_i.restart) |=> state_q == ST_SHUTDN);

  // R11
  stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_en_i && state_q == ST_SLEEP && ctl_i.stay && !ctl_i.shutdn) |=> state_q == ST_SLEEP);
endmodule

// File: rtl/rpwr_drv.sv
module rpwr_drv
  import rpwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  rpwr_state_e        state_i,
  input  rpwr_state_e        state_d_i,
  input  logic               wake_go_i,
  output logic [NUM_OUT-1:0] auto_o
);
  logic pwr_req_q;
  logic wakeup_q;
  logic dom_act;
  logic iso;

  // request lags state by one cycle so isolation leads the drop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_req_q <= 1'b0;
      wakeup_q  <= 1'b0;
    end else begin
      pwr_req_q <= (state_i == ST_PWRON) || (state_i == ST_ACTIVE);
      if (wake_go_i) wakeup_q <= 1'b1;
      else           wakeup_q <= wakeup_q && (state_d_i == ST_PWRON);
    end
  end

  assign dom_act = (state_i == ST_ACTIVE);
  assign iso     = (state_i != ST_ACTIVE);

  assign auto_o[OUT_PWR]  = pwr_req_q;
  assign auto_o[OUT_DOM]  = dom_act;
  assign auto_o[OUT_WAKE] = wakeup_q;
  assign auto_o[OUT_ISO]  = iso;

  // R7
  iso_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso |-> pwr_req_q);

  // R9
  wake_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wakeup_q) |-> $past(state_i) == ST_SLEEP);
endmodule

// File: rtl/rpwr_ovr.sv
module rpwr_ovr
  import rpwr_pkg::*;
#(
  parameter int unsigned N_OUT = NUM_OUT,
  parameter int unsigned FLD_W = OVR_W,
  localparam int unsigned TOT_W = N_OUT * FLD_W
) (
  input  logic             seq_en_i,
  input  logic [TOT_W-1:0] ovr_i,
  input  logic [N_OUT-1:0] auto_i,
  output logic [N_OUT-1:0] out_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [FLD_W-1:0] fld;
    assign fld = ovr_i[k*FLD_W +: FLD_W];
    always_comb begin
      out_o[k] = auto_i[k];
      if (!seq_en_i) begin
        if (fld == OVR_HI)      out_o[k] = 1'b1;
        else if (fld == OVR_LO) out_o[k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rpwr_seq.sv
module rpwr_seq
  import rpwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seq_en_i,
  input  logic               core_dom_req_i,
  input  logic               core_shutdn_i,
  input  logic               host_wake_i,
  input  logic               host_restart_i,
  input  logic               stay_asleep_i,
  input  logic               dbg_force_sleep_i,
  input  logic               dbg_skip_req_i,
  input  logic               pwr_ack_i,
  input  logic [OVR_TOT-1:0] ovr_i,
  output logic               pwr_req_o,
  output logic               dom_active_o,
  output logic               core_wakeup_o,
  output logic               iso_o,
  output logic [2:0]         state_o
);
  rpwr_ctl_t          ctl;
  rpwr_state_e        state, state_d;
  logic               wake_go;
  logic [NUM_OUT-1:0] auto_val;
  logic [NUM_OUT-1:0] out_val;

  assign ctl = '{dom_req: core_dom_req_i, shutdn: core_shutdn_i, wake: host_wake_i,
                 restart: host_restart_i, stay: stay_asleep_i,
                 fsleep: dbg_force_sleep_i, skip: dbg_skip_req_i};

  rpwr_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seq_en_i  (seq_en_i),
    .ctl_i     (ctl),
    .pwr_ack_i (pwr_ack_i),
    .pwr_req_i (auto_val[OUT_PWR]),
    .state_o   (state),
    .state_d_o (state_d),
    .wake_go_o (wake_go)
  );

  rpwr_drv u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .state_d_i (state_d),
    .wake_go_i (wake_go),
    .auto_o    (auto_val)
  );

  rpwr_ovr #(.N_OUT(NUM_OUT), .FLD_W(OVR_W)) u_ovr (
    .seq_en_i (seq_en_i),
    .ovr_i    (ovr_i),
    .auto_i   (auto_val),
    .out_o    (out_val)
  );

  assign pwr_req_o     = out_val[OUT_PWR];
  assign dom_active_o  = out_val[OUT_DOM];
  assign core_wakeup_o = out_val[OUT_WAKE];
  assign iso_o         = out_val[OUT_ISO];
  assign state_o       = state;

  // R4
  ovr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_en_i |-> (out_val == auto_val));
endmodule

// File: tb/rpwr_seq_tb_top.sv
module rpwr_seq_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 24;

  // {en, dom_req, shutdn, wake, restart, stay, fsleep, skip, ack, state[2:0], pwr, dom, wake, iso}
  localparam logic [15:0] VEC [NV] = '{
    16'b1_0_0_0_0_0_0_0_0_001_0001,
    16'b1_0_0_1_0_0_0_0_0_001_0001,
    16'b1_1_0_0_0_0_0_0_0_010_0001,
    16'b1_1_0_0_0_0_0_0_1_010_1001,
    16'b1_1_0_0_0_0_0_0_0_010_1001,
    16'b1_1_0_0_0_0_0_0_1_011_1100,
    16'b1_1_0_0_0_0_0_0_1_011_1100,
    16'b1_0_0_0_0_0_0_0_1_110_1001,
    16'b1_0_0_0_0_0_0_0_1_110_0001,
    16'b1_0_0_1_0_1_0_0_0_110_0001,
    16'b1_0_0_1_0_0_0_0_0_010_0011,
    16'b1_1_0_0_0_0_0_0_0_010_1011,
    16'b1_1_0_0_0_0_0_0_1_011_1100,
    16'b1_1_1_0_0_0_0_0_1_100_1001,
    16'b1_1_0_1_0_0_0_0_0_100_0001,
    16'b1_0_0_0_1_0_0_0_0_001_0001,
    16'b1_0_0_0_0_0_0_1_0_010_0001,
    16'b1_0_0_0_0_0_0_1_1_010_1001,
    16'b1_0_0_0_0_0_0_1_1_011_1100,
    16'b1_0_0_0_0_0_1_1_1_110_1001,
    16'b1_1_0_0_0_0_1_0_0_110_0001,
    16'b1_1_0_0_0_0_0_0_0_010_0001,
    16'b0_0_0_0_0_0_0_0_0_000_1001,
    16'b0_0_0_0_0_0_0_0_0_000_0001
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seq_en = 1'b0, dom_req = 1'b0, shutdn = 1'b0, wake = 1'b0;
  logic       restart = 1'b0, stay = 1'b0, fsleep = 1'b0, skip = 1'b0, ack = 1'b0;
  logic [7:0] ovr = 8'h00;
  logic       pwr_req, dom_act, wakeup, iso;
  logic [2:0] state;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rpwr_seq dut_i (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .seq_en_i          (seq_en),
    .core_dom_req_i    (dom_req),
    .core_shutdn_i     (shutdn),
    .host_wake_i       (wake),
    .host_restart_i    (restart),
    .stay_asleep_i     (stay),
    .dbg_force_sleep_i (fsleep),
    .dbg_skip_req_i    (skip),
    .pwr_ack_i         (ack),
    .ovr_i             (ovr),
    .pwr_req_o         (pwr_req),
    .dom_active_o      (dom_act),
    .core_wakeup_o     (wakeup),
    .iso_o             (iso),
    .state_o           (state)
  );

  function automatic string vec_tag(int i);
    case (i)
      0:                vec_tag = "R1";
      1, 10, 11:        vec_tag = "R9";
      2, 3, 4:          vec_tag = "R5";
      5, 6:             vec_tag = "R6";
      7, 23:            vec_tag = "R7";
      8, 12, 21:        vec_tag = "R8";
      9:                vec_tag = "R11";
      13, 14, 15:       vec_tag = "R10";
      16, 17, 18:       vec_tag = "R13";
      19, 20:           vec_tag = "R12";
      default:          vec_tag = "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {state, pwr_req, dom_act, wakeup, iso};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got state=%0d pwr/dom/wake/iso=%b, expected state=%0d pwr/dom/wake/iso=%b",
               tag, act[6:4], act[3:0], exp[6:4], exp[3:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 7'b000_0001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 7'b000_0001);

    for (int i = 0; i < NV; i++) begin
      {seq_en, dom_req, shutdn, wake, restart, stay, fsleep, skip, ack} = VEC[i][15:7];
      @(negedge clk);
      check(vec_tag(i), VEC[i][6:0]);
    end

    // R3: force pwr/dom/wake high, iso low while disabled
    ovr = 8'b10_11_11_11;
    #1;
    check("R3", 7'b000_1110);
    // R3: codes 1 and 0 leave automatic values, code 2 on pwr keeps it low
    ovr = 8'b00_01_01_10;
    #1;
    check("R3", 7'b000_0001);
    ovr = 8'b11_00_00_00;
    #1;
    check("R3", 7'b000_0001);

    // R4: same forcing pattern with sequencing on has no effect
    ovr = 8'b10_11_11_11;
    seq_en = 1'b1;
    #1;
    check("R4", 7'b000_0001);
    @(negedge clk);
    check("R4", 7'b001_0001);

    // R1: asynchronous reset from ACTIVE
    ovr = 8'h00;
    skip = 1'b1; ack = 1'b1;
    repeat (3) @(negedge clk);
    check("R13", 7'b011_1100);
    rst_n = 1'b0;
    #1;
    check("R1", 7'b000_0001);
    @(negedge clk);
    rst_n = 1'b1;
    seq_en = 1'b0; skip = 1'b0; ack = 1'b0;
    @(negedge clk);
    check("R2", 7'b000_0001);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule